// File: doc/BRIEF.md
# Grayscale PWM Display Period Controller

This block produces the on/off enables for a bank of PWM output channels. A grayscale reference clock drives it, and its clock input is that reference clock. A period counter steps through one display period, one count per reference clock. Each channel is on for the clocks whose index does not exceed that channel's grayscale value. A blank input turns every channel off and abandons the period that is running.

Two period lengths are available. Full resolution uses 2^GS_W clocks. Reduced resolution uses 2^(GS_W-4) clocks and compares only the low GS_W-4 bits of each grayscale value. A repeat-enable input selects the period mode:
- With repeat enabled, a finished period is followed at once by a new one.
- With repeat disabled, the block runs a single period and then holds all outputs off. A new period starts on the next release of blank. It also starts on a latch pulse, if timing reset is enabled.

All inputs are plain level signals sampled on the rising clock edge. The grayscale values are held register contents rather than a data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pwm_disp_top`

## Requirements
- R1: With `res_short`=0 latched for the period, a period has 2^GS_W clocks: the count runs 1, 2, …, 2^GS_W.
- R2: With `res_short`=1 latched for the period, a period has 2^(GS_W-4) clocks. Channel i then uses only bits [GS_W-5:0] of its value.
- R3: A rising edge that samples `blank`=1 drives every `ch_on` bit to 0 after that edge and ends any running period.
- R4: With `rpt_en`=1 at the edge that completes the last clock of a period, the next clock is clock 1 of a new period, and `blank` does not need to change.
- R5: With `rpt_en`=0 at that edge, all outputs go to 0 and stay 0 until a new start. A start is an edge sampling `blank`=0 that follows an edge sampling `blank`=1, or the latch start of R6.
- R6: An edge that samples `latch`=1, `tsync_en`=1 and `blank`=0 starts clock 1 of a new period in either repeat mode, even in the middle of a running period.
- R7: During clock k of a period, channel i is on exactly when k ≤ its effective value. A value of 0 keeps the channel off for the whole period. An all-ones value gives on for every clock except the last.
- R8: `res_short` is sampled only at period starts, both external starts and automatic restarts. Changing it mid-period has no effect on the running period.
- R9: After reset all outputs are 0 and no period runs. The first edge that samples `blank`=0 starts a period at clock 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | 1 forces all outputs off and abandons the period |
| rpt_en | input | 1 | 1 = auto-repeat periods, 0 = single period per start |
| tsync_en | input | 1 | Enables period restart on `latch` |
| latch | input | 1 | Data-latch pulse, one clock wide |
| res_short | input | 1 | 0 = full resolution, 1 = reduced resolution (sampled at period start) |
| gs_vals | input | NUM_CH*GS_W | Grayscale values; channel i occupies bits [i*GS_W +: GS_W] |
| ch_on | output | NUM_CH | Registered channel on enables |

## Verification
Fixed channel values of zero, one and all ones sit next to a random value. Over a single full-resolution period these show the on-count boundaries: none, exactly one, and all but the last clock. Repeat-mode runs with the resolution flipped mid-period test whether the new length waits for the next period start. Short random blank pulses and latch pulses with timing reset on test abandoning and restarting a period at arbitrary counts. A long fully random mix compares every clock against a bench-side model built from the requirements.

// File: rtl/pwm_disp_pkg.sv
package pwm_disp_pkg;

  typedef enum logic {
    RES_FULL  = 1'b0,
    RES_SHORT = 1'b1
  } res_mode_e;

  localparam int unsigned SHORT_DROP = 4;

endpackage

// File: rtl/pwm_period_ctrl.sv
module pwm_period_ctrl
  import pwm_disp_pkg::*;
#(
  parameter int unsigned GS_W    = 16,
  parameter int unsigned SHORT_W = GS_W - SHORT_DROP,
  localparam int unsigned CW     = GS_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          rpt_en,
  input  logic          tsync_en,
  input  logic          latch,
  input  logic          res_short,
  output logic          run_q,
  output logic          run_d,
  output logic [CW-1:0] cnt_d,
  output res_mode_e     mode_d
);

  localparam logic [CW-1:0] LAST_FULL  = CW'(1) << GS_W;
  localparam logic [CW-1:0] LAST_SHORT = CW'(1) << SHORT_W;

  logic          blank_q;
  logic [CW-1:0] cnt_q;
  res_mode_e     mode_q;
  logic [CW-1:0] last_cnt;
  logic          start_req;
  logic          end_hit;

  assign last_cnt  = (mode_q == RES_SHORT) ? LAST_SHORT : LAST_FULL;
  assign start_req = !blank && (blank_q || (latch && tsync_en));
  assign end_hit   = run_q && (cnt_q == last_cnt);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (blank) begin
      run_d = 1'b0;
    end else if (start_req) begin
      run_d  = 1'b1;
      cnt_d  = CW'(1);
      mode_d = res_mode_e'(res_short);
    end else if (run_q) begin
      if (end_hit) begin
        if (rpt_en) begin
          cnt_d  = CW'(1);
          mode_d = res_mode_e'(res_short);
        end else begin
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      run_q   <= 1'b0;
      cnt_q   <= CW'(1);
      mode_q  <= RES_FULL;
    end else begin
      blank_q <= blank;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  // R1, R2: the running count stays inside the latched period length
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q >= CW'(1)) && (cnt_q <= last_cnt));

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !blank && !start_req && !end_hit) |=> (run_q && cnt_q == $past(cnt_q) + CW'(1)));

  assert_auto_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && rpt_en && !blank) |=> (run_q && cnt_q == CW'(1)));

  assert_one_shot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !rpt_en && !blank && !(latch && tsync_en)) |=> !run_q);

  assert_latch_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && tsync_en && !blank) |=> (run_q && cnt_q == CW'(1)));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !blank && !start_req && !end_hit) |=> $stable(mode_q));

  assert_blank_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !run_q);

endmodule

// File: rtl/pwm_ch_bank.sv
module pwm_ch_bank
  import pwm_disp_pkg::*;
#(
  parameter int unsigned NUM_CH  = 12,
  parameter int unsigned GS_W    = 16,
  parameter int unsigned SHORT_W = GS_W - SHORT_DROP,
  localparam int unsigned CW     = GS_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_q,
  input  logic                   run_d,
  input  logic [CW-1:0]          cnt_d,
  input  res_mode_e              mode_d,
  input  logic [NUM_CH*GS_W-1:0] gs_vals,
  output logic [NUM_CH-1:0]      ch_on
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [GS_W-1:0] raw;
    logic [GS_W-1:0] eff;
    logic            on_d;

    assign raw  = gs_vals[i*GS_W +: GS_W];
    assign eff  = (mode_d == RES_SHORT) ? GS_W'(raw[SHORT_W-1:0]) : raw;
    assign on_d = run_d && (cnt_d <= {1'b0, eff});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_on[i] <= 1'b0;
      else        ch_on[i] <= on_d;
    end
  end

  // R5: no channel is on while no period runs
  assert_idle_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (ch_on == '0));

endmodule

// File: rtl/pwm_disp_top.sv
module pwm_disp_top
  import pwm_disp_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned GS_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   blank,
  input  logic                   rpt_en,
  input  logic                   tsync_en,
  input  logic                   latch,
  input  logic                   res_short,
  input  logic [NUM_CH*GS_W-1:0] gs_vals,
  output logic [NUM_CH-1:0]      ch_on
);

  localparam int unsigned SHORT_W = GS_W - SHORT_DROP;
  localparam int unsigned CW      = GS_W + 1;

  logic          run_q;
  logic          run_d;
  logic [CW-1:0] cnt_d;
  res_mode_e     mode_d;

  pwm_period_ctrl #(.GS_W(GS_W), .SHORT_W(SHORT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .blank     (blank),
    .rpt_en    (rpt_en),
    .tsync_en  (tsync_en),
    .latch     (latch),
    .res_short (res_short),
    .run_q     (run_q),
    .run_d     (run_d),
    .cnt_d     (cnt_d),
    .mode_d    (mode_d)
  );

  pwm_ch_bank #(.NUM_CH(NUM_CH), .GS_W(GS_W), .SHORT_W(SHORT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .run_d   (run_d),
    .cnt_d   (cnt_d),
    .mode_d  (mode_d),
    .gs_vals (gs_vals),
    .ch_on   (ch_on)
  );

  assert_blank_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (ch_on == '0));

endmodule

// File: tb/pwm_disp_top_bench.sv
module pwm_disp_top_bench;

  localparam int NCH  = 4;
  localparam int GW   = 8;
  localparam int SW   = GW - 4;
  localparam int NFUL = 1 << GW;
  localparam int NSHT = 1 << SW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              blank = 1'b1;
  logic              rpt_en = 1'b0;
  logic              tsync_en = 1'b0;
  logic              latch = 1'b0;
  logic              res_short = 1'b0;
  logic [NCH*GW-1:0] gs_vals = '0;
  logic [NCH-1:0]    ch_on;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R9";
  int    on_cnt [NCH];

  // bench-side model state
  bit           m_run;
  bit           m_blq;
  int           m_cnt;
  bit           m_mode;
  logic [NCH-1:0] m_on;

  always #5 clk = ~clk;

  pwm_disp_top #(.NUM_CH(NCH), .GS_W(GW)) u_pwm_disp_top (
    .clk(clk), .rst_n(rst_n), .blank(blank), .rpt_en(rpt_en),
    .tsync_en(tsync_en), .latch(latch), .res_short(res_short),
    .gs_vals(gs_vals), .ch_on(ch_on)
  );

  function automatic bit exp_on(bit act, int k, bit md, logic [GW-1:0] g);
    int e;
    e = md ? int'(g[SW-1:0]) : int'(g);
    return act && (k <= e);
  endfunction

  function automatic int period_len(bit md);
    return md ? NSHT : NFUL;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_blq = 1; m_cnt = 1; m_mode = 0; m_on = '0;
    end else begin
      bit st;
      st = !blank && (m_blq || (latch && tsync_en));
      if (blank) m_run = 0;
      else if (st) begin m_run = 1; m_cnt = 1; m_mode = res_short; end
      else if (m_run) begin
        if (m_cnt == period_len(m_mode)) begin
          if (rpt_en) begin m_cnt = 1; m_mode = res_short; end
          else m_run = 0;
        end else m_cnt = m_cnt + 1;
      end
      m_blq = blank;
      for (int i = 0; i < NCH; i++)
        m_on[i] = exp_on(m_run, m_cnt, m_mode, gs_vals[i*GW +: GW]);
    end
  end

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ch_on=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(tag, ch_on, m_on);
    for (int i = 0; i < NCH; i++) if (ch_on[i] === 1'b1) on_cnt[i]++;
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) tick();
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NCH; i++) on_cnt[i] = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    tag = "R9";
    check("R9 reset", ch_on, '0);
    rst_n = 1'b1;
    run(4);
    check("R9 idle under blank", ch_on, '0);

    // R1/R7/R5: one full-resolution single period
    gs_vals = {8'($urandom), 8'h01, 8'h00, 8'hFF};
    rpt_en = 0; res_short = 0;
    clear_counts();
    tag = "R1";
    blank = 0;
    run(NFUL + 40);
    check_int("R7 all-ones on-count", on_cnt[0], NFUL - 1);
    check_int("R7 zero value on-count", on_cnt[1], 0);
    check_int("R7 value one on-count", on_cnt[2], 1);
    tag = "R5";
    run(20);
    check("R5 stays off after single period", ch_on, '0);

    // R5 restart through blank toggle, then R4 auto repeat
    blank = 1; tick(); blank = 0; rpt_en = 1;
    tag = "R4";
    clear_counts();
    run(2 * NFUL);
    check_int("R4 two periods all-ones on-count", on_cnt[0], 2 * (NFUL - 1));

    // R8: flip resolution mid-period
    tag = "R8";
    run(50);
    res_short = 1;
    run(NFUL);
    res_short = 0;
    run(100);

    // R2: reduced resolution with random values
    tag = "R2";
    res_short = 1;
    blank = 1; tick(); blank = 0;
    for (int p = 0; p < 8; p++) begin
      gs_vals = NCH*GW'({$urandom, $urandom});
      run(NSHT);
    end

    // R3: random blank pulses
    tag = "R3";
    for (int c = 0; c < 400; c++) begin
      blank = ($urandom % 23) == 0;
      rpt_en = ($urandom % 5) != 0;
      tick();
    end
    blank = 1; tick();
    check("R3 blank forces off", ch_on, '0);

    // R6: latch starts, also mid-period
    tag = "R6";
    blank = 0; tsync_en = 1; rpt_en = 0; res_short = 0;
    gs_vals = {8'h10, 8'h01, 8'h80, 8'hFF};
    run(NFUL + 10);
    latch = 1; tick(); latch = 0;
    check("R6 latch start clock 1", ch_on, 4'b1111);
    run(30);
    latch = 1; tick(); latch = 0;
    check("R6 latch mid-period restart", ch_on, 4'b1111);
    for (int c = 0; c < 600; c++) begin
      latch = ($urandom % 37) == 0;
      tick();
    end
    latch = 0;

    // mixed random traffic
    tag = "R7";
    for (int c = 0; c < 4000; c++) begin
      blank     = ($urandom % 97) == 0;
      latch     = ($urandom % 61) == 0;
      tsync_en  = ($urandom % 3) != 0;
      rpt_en    = ($urandom % 4) != 0;
      if (($urandom % 150) == 0) res_short = ~res_short;
      if (($urandom % 200) == 0) gs_vals = NCH*GW'({$urandom, $urandom});
      tick();
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule